// File: doc/BRIEF.md
# Masked interrupt status controller

This block gathers single-cycle event pulses from up to sixteen interrupt sources into a pending-status register and combines it with a mask register to drive one interrupt request toward the CPU. Both registers are 16 bits wide and sit on a simple register bus with address, write enable, write data and read data. Bit 3 of the status register is reserved by convention for the combined DMA interrupt; the block treats it like any other source.

Software acknowledges pending events by writing a pattern that is ANDed into the status register: a 0 in the written value clears that bit, and a 1 keeps it. A write to the mask register replaces the whole mask. The request output is registered and recomputed on every clock edge from the updated status and mask. Any write to either register therefore changes the request in the same cycle as the register itself.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the status, the mask, `irq_out` and `bus_rdata` are all cleared to zero.
- R2: A 1 on bit i of `src_evt` at a rising edge sets status bit i from that edge onward.
- R3: A write to offset 0x1070 sets the status to the old status ANDed with `bus_wdata[15:0]`: a 0 clears a bit and a 1 keeps it.
- R4: If an event and an acknowledge that clears the same status bit arrive in the same cycle, the bit ends up set.
- R5: A write to offset 0x1074 loads `bus_wdata[15:0]` into the whole mask. `bus_wdata[31:16]` is ignored.
- R6: `irq_out` is high exactly when (status AND mask) is nonzero. It is updated at the same edge as the registers it depends on, so it changes one cycle after a write or an event.
- R7: A read takes one cycle. `bus_rdata` at the edge after address A was presented holds the status (A=0x1070), the mask (A=0x1074) or zero (any other address), as the register stood before that edge. Bits 31:16 are always zero.
- R8: A write to any address other than 0x1070 and 0x1074 leaves the status and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_evt | input | 16 | Per-source event pulses |
| irq_out | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions check on every cycle that the request matches status AND mask, that a mask write lands with its upper half dropped, and that events always set their bit, including when an acknowledge hits the same bit. They also check that an acknowledge leaves no bit set unless it was kept by the write or set by an event, that writes to other addresses leave the mask alone, and that the upper half of read data stays zero. Read data timing, the exact status value after a mixed acknowledge, and the request rising and falling in response to mask changes are shown only by the bench scenarios. These compare every cycle against a behavioural reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned REG_W    = 16;
  localparam logic [ADDR_W-1:0] STAT_OFS = 16'h1070;
  localparam logic [ADDR_W-1:0] MASK_OFS = 16'h1074;

  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_MASK} reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == STAT_OFS)      return SEL_STAT;
    else if (a == MASK_OFS) return SEL_MASK;
    else                    return SEL_NONE;
  endfunction
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_we,
  input  logic [W-1:0] ack_val,
  input  logic [W-1:0] evt,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_nx
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic keep;
    assign keep         = ack_we ? ack_val[i] : 1'b1;
    // event wins over a same-cycle clear
    assign status_nx[i] = evt[i] | (status_q[i] & keep);
    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_nx[i];
    end
  end
endmodule

// File: rtl/irqc_maskreg.sv
module irqc_maskreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_nx
);
  assign mask_nx = load ? load_val : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nx;
  end
endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
  import irqc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  reg_sel_e      sel,
  input  logic [RW-1:0] status_q,
  input  logic [RW-1:0] mask_q,
  output logic [DW-1:0] rdata
);
  localparam int unsigned PAD_W = DW - RW;
  logic [RW-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_STAT: pick = status_q;
      SEL_MASK: pick = mask_q;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{PAD_W{1'b0}}, pick};
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [REG_W-1:0]  src_evt,
  output logic              irq_out
);
  reg_sel_e         sel;
  logic [REG_W-1:0] stat_q, stat_nx, mask_q, mask_nx;
  logic             irq_q;

  assign sel = decode(bus_addr);

  irqc_pending #(.W(REG_W)) u_pend (
    .clk(clk), .rst(rst),
    .ack_we(bus_we && sel == SEL_STAT),
    .ack_val(bus_wdata[REG_W-1:0]),
    .evt(src_evt),
    .status_q(stat_q), .status_nx(stat_nx)
  );

  irqc_maskreg #(.W(REG_W)) u_mask (
    .clk(clk), .rst(rst),
    .load(bus_we && sel == SEL_MASK),
    .load_val(bus_wdata[REG_W-1:0]),
    .mask_q(mask_q), .mask_nx(mask_nx)
  );

  irqc_readmux #(.DW(DATA_W), .RW(REG_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel),
    .status_q(stat_q), .mask_q(mask_q), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_nx & mask_nx);
  end
  assign irq_out = irq_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [REG_W-1:0]  src_evt,
  input logic              irq_out,
  input logic [REG_W-1:0]  stat_q,
  input logic [REG_W-1:0]  mask_q
);
  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(stat_q & mask_q));
  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == MASK_OFS) |=> mask_q == $past(bus_wdata[REG_W-1:0]));
  // R2 and R4
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (src_evt != '0) |=> (stat_q & $past(src_evt)) == $past(src_evt));
  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == STAT_OFS)
      |=> (stat_q & ~$past(bus_wdata[REG_W-1:0]) & ~$past(src_evt)) == '0);
  // R8
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == MASK_OFS) |=> $stable(mask_q));
  // R7
  rd_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:REG_W] == '0);
endmodule

bind irqc_top irqc_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
  .irq_out(irq_out), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/100ps
module irqc_top_tb;
  localparam logic [15:0] ST = 16'h1070;
  localparam logic [15:0] MK = 16'h1074;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] src_evt = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] m_stat = '0, m_mask = '0;
  logic [31:0] m_rd = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; model updated from the inputs seen at the edge
  task automatic step(string tag, logic [15:0] a, logic we, logic [31:0] wd, logic [15:0] ev);
    logic [15:0] keep;
    bus_addr = a; bus_we = we; bus_wdata = wd; src_evt = ev;
    @(posedge clk);
    m_rd   = (a == ST) ? {16'h0, m_stat} : (a == MK) ? {16'h0, m_mask} : 32'h0;
    keep   = (we && a == ST) ? wd[15:0] : 16'hFFFF;
    m_stat = (m_stat & keep) | ev;
    if (we && a == MK) m_mask = wd[15:0];
    m_irq  = (m_stat & m_mask) != 0;
    #1;
    check({tag, " rdata"}, bus_rdata, m_rd);
    check({tag, " irq R6"}, {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    rst = 1'b0;
    step("R1 status read", ST, 1'b0, 32'h0, 16'h0);
    step("R1 mask read", MK, 1'b0, 32'h0, 16'h0);
    step("R2 evt bit3", ST, 1'b0, 32'h0, 16'h0008);
    step("R2 read", ST, 1'b0, 32'h0, 16'h0);
    step("R5 mask write", MK, 1'b1, 32'hABCD_0008, 16'h0);
    step("R7 mask read", MK, 1'b0, 32'hFFFF_FFFF, 16'h0);
    step("R3 keep all", ST, 1'b1, 32'h0000_FFFF, 16'h0);
    step("R3 clear bit3", ST, 1'b1, 32'h0000_FFF7, 16'h0);
    step("R3 read", ST, 1'b0, 32'h0, 16'h0);
    step("R2 evts", 16'h0, 1'b0, 32'h0, 16'h0021);
    step("R4 set wins", ST, 1'b1, 32'h0, 16'h0001);
    step("R4 read", ST, 1'b0, 32'h0, 16'h0);
    step("R8 stray write", 16'h1078, 1'b1, 32'h0, 16'h0);
    step("R8 read st", ST, 1'b0, 32'h0, 16'h0);
    step("R7 stray read", 16'h1078, 1'b0, 32'h0, 16'h0);
    step("R6 unmask", MK, 1'b1, 32'h0000_FFFF, 16'h0);
    step("R6 evt hi", MK, 1'b0, 32'h0, 16'h8000);
    step("R6 mask off", MK, 1'b1, 32'h0, 16'h0);
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R3 R5 random",
           lf[1:0] == 2'd0 ? ST : lf[1:0] == 2'd1 ? MK : 16'h1000,
           lf[2], {lf, lf ^ 16'h5A5A},
           lf[3] ? (16'h1 << lf[7:4]) : 16'h0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule